// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block is the digital control core for one phase of a synchronous buck power stage. It produces two gate-enable outputs, one for the high-side switch and one for the low-side switch. A three-level PWM command and a three-level enable command arrive already digitized as 2-bit level codes. The block inserts a programmable non-overlap interval whenever it hands conduction from one switch to the other, so the two enables are never high together.

A mid-level PWM command starts a diode-emulation sequence. The high side turns off at once. After the non-overlap interval the low side turns on. The zero-cross input is ignored for a fixed blanking window. After that window, a zero-cross indication releases the low side, and it stays off while PWM remains mid. A mid enable level holds both outputs low for body-diode braking. An under-voltage lockout flag, built from two supply-comparator inputs with hysteresis, also holds both outputs low.

Level codes on both command inputs are 2'b00 low, 2'b01 mid, 2'b10 high and 2'b11 illegal.

Top module: `buck_gate_sequencer`

## Requirements
- R1: `hs_gate_en` and `ls_gate_en` are never high in the same cycle.
- R2: When PWM changes to high (2'b10) with the driver enabled, both outputs stay low for DT_CYC cycles starting at the edge that samples the change. `hs_gate_en` rises at the next edge, DT_CYC+1 edges after the change.
- R3: PWM low (2'b00) gives the same sequence as R2, with `ls_gate_en` as the output that turns on.
- R4: When PWM changes to mid (2'b01), `hs_gate_en` falls at the first edge. After DT_CYC cycles with both outputs low, `ls_gate_en` rises.
- R5: Once the low side is on in mid, it stays on for at least BLANK_CYC+1 cycles whatever `zc_det` does. BLANK_CYC is BLANK_PS/CLK_PERIOD_PS rounded up.
- R6: After blanking, an edge that samples `zc_det` high turns `ls_gate_en` off. It stays off while PWM stays mid. A later PWM high or low clears this state and runs the normal sequence.
- R7: Enable high (2'b10) runs the driver. Enable mid (2'b01) or low (2'b00) drives both outputs low from the first edge that samples it. When enable returns to high, the PWM sequence restarts with the full non-overlap interval.
- R8: The lockout flag sets when both `vcc_above_rise` and `vcc_above_fall` are low. It clears when `vcc_above_rise` is high, and it holds its value otherwise. Outputs go low one edge after the flag sets. The sequence starts one edge after the flag clears.
- R9: A command change during a non-overlap or blanking interval aborts the sequence. The new sequence starts from both-outputs-low with a full non-overlap interval counted from the change.
- R10: The illegal code 2'b11 on either PWM or enable drives both outputs low from the first edge that samples it.
- R11: During and after reset both outputs are low and lockout is set. The outputs stay low until `vcc_above_rise` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_lvl | input | 2 | PWM level code (00 low, 01 mid, 10 high, 11 illegal) |
| en_lvl | input | 2 | Enable level code (00 low, 01 mid, 10 high, 11 illegal) |
| vcc_above_rise | input | 1 | Supply is above the rising lockout threshold |
| vcc_above_fall | input | 1 | Supply is above the falling (hysteresis-lowered) threshold |
| zc_det | input | 1 | Inductor current has reached zero or gone negative |
| hs_gate_en | output | 1 | High-side gate enable |
| ls_gate_en | output | 1 | Low-side gate enable |

## Verification
The bench builds the block with DT_CYC = 3 and a 5000 ps clock period. BLANK_PS = 20000 shortens blanking to four cycles, and HYST_EN = 1 selects the two-threshold lockout. With these values a zero-cross that is held high from the first low-side cycle lands on the exact edge where blanking ends. Aborts inside the dead-time and blanking windows, and the hold and release of the hysteresis flag, are each reached within a few cycles. Every expected output is derived cycle by cycle from these small counts.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
   typedef enum logic [1:0] {
      LVL_LOW  = 2'b00,
      LVL_MID  = 2'b01,
      LVL_HIGH = 2'b10,
      LVL_BAD  = 2'b11
   } lvl_e;

   typedef enum logic [1:0] {
      CMD_OFF,
      CMD_HS,
      CMD_LS,
      CMD_DE
   } cmd_e;

   typedef enum logic [3:0] {
      ST_OFF,
      ST_DT_HS,
      ST_HS,
      ST_DT_LS,
      ST_LS,
      ST_DT_DE,
      ST_DE_BLANK,
      ST_DE_WATCH,
      ST_DE_DONE
   } st_e;

   // command a sequencer state belongs to
   function automatic cmd_e st_cmd(st_e s);
      case (s)
         ST_DT_HS, ST_HS:                                   return CMD_HS;
         ST_DT_LS, ST_LS:                                   return CMD_LS;
         ST_DT_DE, ST_DE_BLANK, ST_DE_WATCH, ST_DE_DONE:    return CMD_DE;
         default:                                           return CMD_OFF;
      endcase
   endfunction
endpackage

// File: rtl/bsq_uvlo.sv
module bsq_uvlo #(
   parameter bit HYST_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic above_rise,
   input  logic above_fall,
   output logic lockout
);
   logic lock_q;

   generate
      if (HYST_EN) begin : g_hyst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      lock_q <= 1'b1;
            else if (above_rise)             lock_q <= 1'b0;
            else if (!above_fall)            lock_q <= 1'b1;
         end
      end else begin : g_plain
         logic unused_fall;
         assign unused_fall = above_fall;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lock_q <= 1'b1;
            else        lock_q <= !above_rise;
         end
      end
   endgenerate

   assign lockout = lock_q;
endmodule

// File: rtl/bsq_cmd_decode.sv
module bsq_cmd_decode
   import bsq_pkg::*;
(
   input  logic [1:0] pwm_lvl,
   input  logic [1:0] en_lvl,
   input  logic       lockout,
   output cmd_e       cmd
);
   always_comb begin
      cmd = CMD_OFF;
      if (!lockout && (lvl_e'(en_lvl) == LVL_HIGH)) begin
         case (lvl_e'(pwm_lvl))
            LVL_HIGH: cmd = CMD_HS;
            LVL_LOW:  cmd = CMD_LS;
            LVL_MID:  cmd = CMD_DE;
            default:  cmd = CMD_OFF;
         endcase
      end
   end
endmodule

// File: rtl/bsq_seq.sv
module bsq_seq
   import bsq_pkg::*;
#(
   parameter int DT_CYC    = 4,
   parameter int BLANK_CYC = 70
) (
   input  logic clk,
   input  logic rst_n,
   input  cmd_e cmd,
   input  logic zc,
   output logic hs_on,
   output logic ls_on
);
   localparam int MAXC = (DT_CYC > BLANK_CYC) ? DT_CYC : BLANK_CYC;
   localparam int CW   = $clog2(MAXC + 1);
   localparam logic [CW-1:0] DT_LOAD = CW'(DT_CYC - 1);
   localparam logic [CW-1:0] BL_LOAD = CW'(BLANK_CYC - 1);

   st_e           st_q, st_d;
   logic [CW-1:0] cnt_q, cnt_d;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      if (cmd != st_cmd(st_q)) begin
         cnt_d = DT_LOAD;
         case (cmd)
            CMD_HS:  st_d = ST_DT_HS;
            CMD_LS:  st_d = ST_DT_LS;
            CMD_DE:  st_d = ST_DT_DE;
            default: st_d = ST_OFF;
         endcase
      end else begin
         case (st_q)
            ST_DT_HS: begin
               if (cnt_q == '0) st_d = ST_HS;
               else             cnt_d = cnt_q - 1'b1;
            end
            ST_DT_LS: begin
               if (cnt_q == '0) st_d = ST_LS;
               else             cnt_d = cnt_q - 1'b1;
            end
            ST_DT_DE: begin
               if (cnt_q == '0) begin
                  st_d  = ST_DE_BLANK;
                  cnt_d = BL_LOAD;
               end else begin
                  cnt_d = cnt_q - 1'b1;
               end
            end
            ST_DE_BLANK: begin
               if (cnt_q == '0) st_d = ST_DE_WATCH;
               else             cnt_d = cnt_q - 1'b1;
            end
            ST_DE_WATCH: begin
               if (zc) st_d = ST_DE_DONE;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_OFF;
         cnt_q <= '0;
         hs_on <= 1'b0;
         ls_on <= 1'b0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
         hs_on <= (st_d == ST_HS);
         ls_on <= (st_d == ST_LS) || (st_d == ST_DE_BLANK) || (st_d == ST_DE_WATCH);
      end
   end
endmodule

// File: rtl/buck_gate_sequencer.sv
module buck_gate_sequencer
   import bsq_pkg::*;
#(
   parameter int DT_CYC        = 4,
   parameter int CLK_PERIOD_PS = 5000,
   parameter int BLANK_PS      = 350000,
   parameter bit HYST_EN       = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] pwm_lvl,
   input  logic [1:0] en_lvl,
   input  logic       vcc_above_rise,
   input  logic       vcc_above_fall,
   input  logic       zc_det,
   output logic       hs_gate_en,
   output logic       ls_gate_en
);
   localparam int BLANK_CYC = (BLANK_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;

   generate
      if (DT_CYC < 1) begin : g_bad_dt
         $error("DT_CYC must be at least 1");
      end
      if (CLK_PERIOD_PS < 1) begin : g_bad_clk
         $error("CLK_PERIOD_PS must be positive");
      end
      if (BLANK_CYC < 1) begin : g_bad_blank
         $error("BLANK_PS must give at least one blanking cycle");
      end
   endgenerate

   logic lockout;
   cmd_e cmd;

   bsq_uvlo #(.HYST_EN(HYST_EN)) u_uvlo (
      .clk        (clk),
      .rst_n      (rst_n),
      .above_rise (vcc_above_rise),
      .above_fall (vcc_above_fall),
      .lockout    (lockout)
   );

   bsq_cmd_decode u_dec (
      .pwm_lvl (pwm_lvl),
      .en_lvl  (en_lvl),
      .lockout (lockout),
      .cmd     (cmd)
   );

   bsq_seq #(.DT_CYC(DT_CYC), .BLANK_CYC(BLANK_CYC)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .cmd   (cmd),
      .zc    (zc_det),
      .hs_on (hs_gate_en),
      .ls_on (ls_gate_en)
   );
endmodule

// File: rtl/bsq_checks.sv
module bsq_checks #(
   parameter int DT_CYC = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] pwm_lvl,
   input logic [1:0] en_lvl,
   input logic       vcc_above_rise,
   input logic       vcc_above_fall,
   input logic       hs_gate_en,
   input logic       ls_gate_en
);
   int off_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            off_run <= 0;
      else if (hs_gate_en || ls_gate_en)     off_run <= 0;
      else if (off_run < DT_CYC)             off_run <= off_run + 1;
   end

   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_gate_en && ls_gate_en)); // R1

   AST_HS_DEADTIME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_gate_en) |-> (off_run >= DT_CYC)); // R2

   AST_LS_DEADTIME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_gate_en) |-> (off_run >= DT_CYC)); // R3

   AST_EN_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (en_lvl != 2'b10) |=> (!hs_gate_en && !ls_gate_en)); // R7

   AST_ILLEGAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_lvl == 2'b11 || en_lvl == 2'b11) |=> (!hs_gate_en && !ls_gate_en)); // R10

   AST_UVLO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!vcc_above_rise && !vcc_above_fall) |-> ##2 (!hs_gate_en && !ls_gate_en)); // R8
endmodule

bind buck_gate_sequencer bsq_checks #(.DT_CYC(DT_CYC)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .pwm_lvl        (pwm_lvl),
   .en_lvl         (en_lvl),
   .vcc_above_rise (vcc_above_rise),
   .vcc_above_fall (vcc_above_fall),
   .hs_gate_en     (hs_gate_en),
   .ls_gate_en     (ls_gate_en)
);

// File: tb/sim_buck_gate_sequencer.sv
`timescale 1ns/1ps
module sim_buck_gate_sequencer;
   localparam int DT = 3;
   localparam logic [1:0] LO = 2'b00, MD = 2'b01, HI = 2'b10, BD = 2'b11;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] pwm = LO;
   logic [1:0] en = HI;
   logic       rise = 1'b0;
   logic       fall = 1'b1;
   logic       zc = 1'b0;
   logic       hs, ls;

   int cyc = 0;
   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   typedef struct {
      int    stamp;
      logic  hs;
      logic  ls;
      string tag;
   } exp_t;
   exp_t q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   buck_gate_sequencer #(
      .DT_CYC(DT), .CLK_PERIOD_PS(5000), .BLANK_PS(20000), .HYST_EN(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .pwm_lvl(pwm), .en_lvl(en),
      .vcc_above_rise(rise), .vcc_above_fall(fall), .zc_det(zc),
      .hs_gate_en(hs), .ls_gate_en(ls)
   );

   task automatic compare(input logic ah, input logic al, input logic eh,
                          input logic el, input string tag);
      compared++;
      if (ah !== eh || al !== el) begin
         mismatched++;
         $display("FAIL %s: actual hs=%b ls=%b expected hs=%b ls=%b (cycle %0d)",
                  tag, ah, al, eh, el, cyc);
      end
   endtask

   // monitor: pops every expectation due in this cycle
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].stamp == cyc) begin
         exp_t it;
         it = q.pop_front();
         compare(hs, ls, it.hs, it.ls, it.tag);
      end
   end

   // driver: set inputs, expect outputs after the next edge
   task automatic step(input logic [1:0] p, input logic [1:0] e, input logic r,
                       input logic f, input logic z, input logic eh,
                       input logic el, input string tag);
      @(negedge clk);
      pwm = p; en = e; rise = r; fall = f; zc = z;
      q.push_back('{cyc + 1, eh, el, tag});
   endtask

   task automatic hold(input int n, input logic [1:0] p, input logic [1:0] e,
                       input logic r, input logic f, input logic z,
                       input logic eh, input logic el, input string tag);
      for (int i = 0; i < n; i++) step(p, e, r, f, z, eh, el, tag);
   endtask

   // DT cycles both-off, then the target output on
   task automatic handover(input logic [1:0] p, input logic [1:0] e, input logic z,
                           input logic eh, input logic el, input string tag);
      hold(DT, p, e, 1'b1, 1'b1, z, 1'b0, 1'b0, tag);
      step(p, e, 1'b1, 1'b1, z, eh, el, tag);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare(hs, ls, 1'b0, 1'b0, "R11 reset outputs");
      rst_n = 1'b1;
      // lockout set from reset: no drive while rise is low
      hold(4, LO, HI, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R11 lockout after reset");
      // release: flag clears, then sequence starts
      step(LO, HI, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R8 release edge");
      handover(LO, HI, 1'b0, 1'b0, 1'b1, "R3 low side on");
      hold(3, LO, HI, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R3 low side held");
      handover(HI, HI, 1'b0, 1'b1, 1'b0, "R2 high side on");
      hold(2, HI, HI, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R2 high side held");
      // mid: hs off at once, ls after DT, zc high ignored through blanking
      step(MD, HI, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4 hs off at once");
      hold(DT - 1, MD, HI, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R4 dead time");
      step(MD, HI, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R4 ls on in mid");
      hold(4, MD, HI, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R5 zc ignored in blanking");
      step(MD, HI, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R6 zc releases ls");
      hold(4, MD, HI, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R6 stays low in mid");
      hold(2, MD, HI, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R6 stays low with zc");
      handover(LO, HI, 1'b0, 1'b0, 1'b1, "R6 low clears zc state");
      hold(2, LO, HI, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R3 low side held");
      // mid without zero cross: ls stays on past blanking
      handover(MD, HI, 1'b0, 1'b0, 1'b1, "R4 ls on in mid");
      hold(9, MD, HI, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R5 ls held without zc");
      step(MD, HI, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R6 zc after blanking");
      step(MD, HI, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R6 stays low");
      handover(HI, HI, 1'b0, 1'b1, 1'b0, "R6 high clears zc state");
      // abort inside dead time
      step(LO, HI, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9 start low sequence");
      handover(HI, HI, 1'b0, 1'b1, 1'b0, "R9 abort to high");
      // abort inside blanking
      handover(MD, HI, 1'b0, 1'b0, 1'b1, "R4 ls on in mid");
      step(MD, HI, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R5 blanking");
      handover(HI, HI, 1'b0, 1'b1, 1'b0, "R9 abort blanking to high");
      // enable levels
      step(HI, MD, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R7 enable mid off");
      hold(3, HI, MD, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R7 enable mid held");
      hold(2, LO, MD, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R7 enable mid ignores pwm");
      handover(LO, HI, 1'b0, 1'b0, 1'b1, "R7 enable high restart");
      step(LO, LO, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R7 enable low off");
      hold(2, LO, LO, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R7 enable low held");
      handover(HI, HI, 1'b0, 1'b1, 1'b0, "R7 enable high restart");
      // illegal codes
      step(BD, HI, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R10 illegal pwm");
      hold(2, BD, HI, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R10 illegal pwm held");
      handover(HI, HI, 1'b0, 1'b1, 1'b0, "R10 recover");
      step(HI, BD, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R10 illegal enable");
      hold(2, HI, BD, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R10 illegal enable held");
      handover(HI, HI, 1'b0, 1'b1, 1'b0, "R10 recover");
      // lockout hysteresis
      hold(3, HI, HI, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R8 in hysteresis band runs");
      step(HI, HI, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8 flag sets");
      step(HI, HI, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 outputs off");
      hold(3, HI, HI, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8 held in band");
      step(HI, HI, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R8 release edge");
      handover(HI, HI, 1'b0, 1'b1, 1'b0, "R8 restart after release");
      repeat (2) @(negedge clk);
      if (q.size() != 0) begin
         mismatched++;
         $display("FAIL R1: actual %0d pending expectations, expected 0", q.size());
      end
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         mismatched++;
         $display("FAIL watchdog: actual hung, expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule